// File: doc/BRIEF.md
# Knob Position Counter

This block turns the two raw contact signals of a mechanical rotary knob into a bounded position count and an eight-bit LED indicator. Both raw contacts are first brought into the clock domain by a flop synchroniser. Each contact then passes through a level-pair latch, so that bounce on one contact cannot make a false step. One filtered contact, the edge phase, triggers a step when it rises cleanly. The other, the direction phase, decides whether that step counts up or down.

The position lies between zero and an upper bound. A step that would leave this range sends the count back to zero. Each LED output marks one fixed position that is a multiple of a step size. The LED outputs are registered.

Top module: `knob_position_counter`

## Requirements
- R1: A synchronous active-high `rst` clears the position, all LED outputs, both filtered phases, the edge-delay register and the synchroniser flops to 0.
- R2: The filtered edge phase is cleared when both synchronised contacts are 0 and set when both are 1. It keeps its value when the two contacts differ, so contact chatter between the states (edge=0,dir=1) and (0,0) makes no step.
- R3: The filtered direction phase is set when the direction contact is 1 and the edge contact is 0. It is cleared when the direction contact is 0 and the edge contact is 1. It keeps its value when the two contacts are equal, so a move from (0,0) straight to (1,1) uses the direction seen at the last mixed state.
- R4: A step is taken only on a clock where the filtered edge phase is 1 and was 0 one clock earlier. Holding both contacts high, or chatter between (1,1) and (1,0), gives no further step.
- R5: On a step the position goes up by one when the filtered direction phase is 1, and down by one when it is 0.
- R6: The position never goes above `MAX_POS` (default 80). An up-step at `MAX_POS` sets it to 0, and a down-step at 0 leaves it at 0.
- R7: LED bit i (i = 0 to `LED_N`-1) is 1 exactly when the position equals `LED_STEP`*(i+1) (defaults 10 and 8), and 0 at every other position.
- R8: A raw contact change reaches the position on the fourth rising clock edge after it is applied: two synchroniser stages, the filter and the counter. The LED outputs follow one clock after the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_raw_i | input | 1 | Raw contact whose filtered rise triggers a step |
| dir_raw_i | input | 1 | Raw contact whose filtered level picks the direction |
| pos_o | output | $clog2(MAX_POS+1) | Current knob position |
| led_o | output | LED_N | Registered position markers |

## Verification
A step and the range limit can act in the same cycle. This happens when a rising edge of the filtered edge phase arrives while the count is at `MAX_POS` with the direction set to up, or at 0 with the direction set to down. The bench provokes it by sweeping more than `MAX_POS` up-detents from reset, and by turning down past zero. It expects the count to go to 0 rather than 81, and to stay at 0 rather than go negative. In the same cycle the top LED bit must drop one clock after the wrap.

// File: rtl/kpc_pkg.sv
package kpc_pkg;

   typedef enum logic [1:0] {
      MOVE_NONE = 2'd0,
      MOVE_UP   = 2'd1,
      MOVE_DOWN = 2'd2
   } move_e;

   function automatic int unsigned pos_bits(input int unsigned top_val);
      return (top_val < 2) ? 1 : $clog2(top_val + 1);
   endfunction

endpackage

// File: rtl/kpc_sync.sv
module kpc_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("kpc_sync: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("kpc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/kpc_contact_filter.sv
module kpc_contact_filter #(
   parameter bit IS_DIR = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic own_i,
   input  logic other_i,
   output logic flt_o
);

   logic flt_d;

   if (IS_DIR == 1'b0) begin : g_edge_rule
      // equal levels decide, mixed levels keep
      always_comb begin
         flt_d = flt_o;
         if (own_i == other_i) flt_d = own_i;
      end
   end else begin : g_dir_rule
      // mixed levels decide, equal levels keep
      always_comb begin
         flt_d = flt_o;
         if (own_i != other_i) flt_d = own_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) flt_o <= 1'b0;
      else     flt_o <= flt_d;
   end

endmodule

// File: rtl/kpc_step_detect.sv
module kpc_step_detect
   import kpc_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  edge_flt_i,
   input  logic  dir_flt_i,
   output move_e move_o,
   output logic  edge_dly_o
);

   always_ff @(posedge clk) begin
      if (rst) edge_dly_o <= 1'b0;
      else     edge_dly_o <= edge_flt_i;
   end

   always_comb begin
      move_o = MOVE_NONE;
      if (edge_flt_i && !edge_dly_o) move_o = dir_flt_i ? MOVE_UP : MOVE_DOWN;
   end

endmodule

// File: rtl/kpc_pos_counter.sv
module kpc_pos_counter
   import kpc_pkg::*;
#(
   parameter int unsigned MAX_POS = 80,
   parameter int unsigned PW      = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  move_e         move_i,
   output logic [PW-1:0] pos_o
);

   localparam logic [PW-1:0] TOP = PW'(MAX_POS);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_o <= '0;
      end else begin
         case (move_i)
            MOVE_UP:   pos_o <= (pos_o >= TOP) ? '0 : pos_o + 1'b1;
            MOVE_DOWN: pos_o <= (pos_o == '0 || pos_o > TOP) ? '0 : pos_o - 1'b1;
            default:   pos_o <= pos_o;
         endcase
      end
   end

endmodule

// File: rtl/kpc_led_decode.sv
module kpc_led_decode #(
   parameter int unsigned LED_N    = 8,
   parameter int unsigned LED_STEP = 10,
   parameter int unsigned PW       = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PW-1:0]    pos_i,
   output logic [LED_N-1:0] led_o
);

   for (genvar i = 0; i < LED_N; i++) begin : g_mark
      localparam logic [PW-1:0] MARK = PW'(LED_STEP * (i + 1));
      always_ff @(posedge clk) begin
         if (rst) led_o[i] <= 1'b0;
         else     led_o[i] <= (pos_i == MARK);
      end
   end

endmodule

// File: rtl/knob_position_counter.sv
module knob_position_counter #(
   parameter int unsigned MAX_POS     = 80,
   parameter int unsigned LED_N       = 8,
   parameter int unsigned LED_STEP    = 10,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PW         = kpc_pkg::pos_bits(MAX_POS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             edge_raw_i,
   input  logic             dir_raw_i,
   output logic [PW-1:0]    pos_o,
   output logic [LED_N-1:0] led_o
);

   import kpc_pkg::*;

   if (MAX_POS < 1) begin : g_bad_max
      $error("knob_position_counter: MAX_POS must be at least 1");
   end
   if (LED_N < 1 || LED_STEP < 1) begin : g_bad_led
      $error("knob_position_counter: LED_N and LED_STEP must be at least 1");
   end
   if (LED_N * LED_STEP > MAX_POS) begin : g_bad_marks
      $error("knob_position_counter: top LED mark lies above MAX_POS");
   end

   logic [1:0] sync_q;
   logic       edge_s;
   logic       dir_s;
   logic       edge_flt;
   logic       dir_flt;
   logic       edge_dly;
   move_e      move;

   kpc_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({dir_raw_i, edge_raw_i}),
      .q_o (sync_q)
   );

   assign edge_s = sync_q[0];
   assign dir_s  = sync_q[1];

   kpc_contact_filter #(.IS_DIR(1'b0)) u_edge_flt (
      .clk     (clk),
      .rst     (rst),
      .own_i   (edge_s),
      .other_i (dir_s),
      .flt_o   (edge_flt)
   );

   kpc_contact_filter #(.IS_DIR(1'b1)) u_dir_flt (
      .clk     (clk),
      .rst     (rst),
      .own_i   (dir_s),
      .other_i (edge_s),
      .flt_o   (dir_flt)
   );

   kpc_step_detect u_step (
      .clk        (clk),
      .rst        (rst),
      .edge_flt_i (edge_flt),
      .dir_flt_i  (dir_flt),
      .move_o     (move),
      .edge_dly_o (edge_dly)
   );

   kpc_pos_counter #(
      .MAX_POS (MAX_POS),
      .PW      (PW)
   ) u_count (
      .clk    (clk),
      .rst    (rst),
      .move_i (move),
      .pos_o  (pos_o)
   );

   kpc_led_decode #(
      .LED_N    (LED_N),
      .LED_STEP (LED_STEP),
      .PW       (PW)
   ) u_leds (
      .clk   (clk),
      .rst   (rst),
      .pos_i (pos_o),
      .led_o (led_o)
   );

endmodule

// File: rtl/kpc_checker.sv
module kpc_checker #(
   parameter int unsigned MAX_POS  = 80,
   parameter int unsigned LED_N    = 8,
   parameter int unsigned LED_STEP = 10,
   parameter int unsigned PW       = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             edge_s,
   input logic             dir_s,
   input logic             edge_flt,
   input logic             dir_flt,
   input logic             edge_dly,
   input logic [PW-1:0]    pos_o,
   input logic [LED_N-1:0] led_o
);

   localparam logic [PW-1:0] TOP = PW'(MAX_POS);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pos_o == '0 && led_o == '0));

   // R2
   edge_set_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_s && dir_s) |=> edge_flt);
   // R2
   edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!edge_s && !dir_s) |=> !edge_flt);
   // R2
   edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_s != dir_s) |=> $stable(edge_flt));

   // R3
   dir_set_chk: assert property (@(posedge clk) disable iff (rst)
      (dir_s && !edge_s) |=> dir_flt);
   // R3
   dir_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!dir_s && edge_s) |=> !dir_flt);
   // R3
   dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (dir_s == edge_s) |=> $stable(dir_flt));

   // R4
   no_step_chk: assert property (@(posedge clk) disable iff (rst)
      !(edge_flt && !edge_dly) |=> $stable(pos_o));

   // R5
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_flt && !edge_dly && dir_flt && pos_o < TOP) |=> (pos_o == $past(pos_o) + 1'b1));
   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_flt && !edge_dly && !dir_flt && pos_o != '0) |=> (pos_o == $past(pos_o) - 1'b1));

   // R6
   in_range_chk: assert property (@(posedge clk) disable iff (rst)
      pos_o <= TOP);
   // R6
   wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_flt && !edge_dly && dir_flt && pos_o == TOP) |=> (pos_o == '0));
   // R6
   floor_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_flt && !edge_dly && !dir_flt && pos_o == '0) |=> (pos_o == '0));

   // R7
   led_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(led_o));

   for (genvar i = 0; i < LED_N; i++) begin : g_led_chk
      localparam logic [PW-1:0] MARK = PW'(LED_STEP * (i + 1));
      // R8
      led_on_lag_chk: assert property (@(posedge clk) disable iff (rst)
         (pos_o == MARK) |=> led_o[i]);
      // R7
      led_off_lag_chk: assert property (@(posedge clk) disable iff (rst)
         (pos_o != MARK) |=> !led_o[i]);
   end

endmodule

bind knob_position_counter kpc_checker #(
   .MAX_POS  (MAX_POS),
   .LED_N    (LED_N),
   .LED_STEP (LED_STEP),
   .PW       (PW)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .edge_s   (edge_s),
   .dir_s    (dir_s),
   .edge_flt (edge_flt),
   .dir_flt  (dir_flt),
   .edge_dly (edge_dly),
   .pos_o    (pos_o),
   .led_o    (led_o)
);

// File: tb/knob_position_counter_tb.sv
module knob_position_counter_tb;

   localparam int MAXP  = 80;
   localparam int LEDS  = 8;
   localparam int LSTEP = 10;
   localparam int HOLD  = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       edge_raw = 1'b0;
   logic       dir_raw  = 1'b0;
   logic [6:0] pos;
   logic [7:0] led;

   int checks = 0;
   int errors = 0;
   int exp_pos = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   knob_position_counter u_dut (
      .clk        (clk),
      .rst        (rst),
      .edge_raw_i (edge_raw),
      .dir_raw_i  (dir_raw),
      .pos_o      (pos),
      .led_o      (led)
   );

   function automatic logic [7:0] led_for(input int p);
      logic [7:0] v = '0;
      for (int i = 0; i < LEDS; i++) v[i] = (p == LSTEP * (i + 1));
      return v;
   endfunction

   task automatic chk_pos(input string req, input int expv);
      checks++;
      if (int'(pos) != expv) begin
         errors++;
         $display("FAIL %s position: actual %0d expected %0d", req, pos, expv);
      end
   endtask

   task automatic chk_led(input string req, input logic [7:0] expv);
      checks++;
      if (led !== expv) begin
         errors++;
         $display("FAIL %s leds: actual %b expected %b", req, led, expv);
      end
   endtask

   task automatic chk_state(input string req);
      chk_pos(req, exp_pos);
      chk_led({req, " R7"}, led_for(exp_pos));
   endtask

   task automatic set_raw(input logic e, input logic d);
      @(negedge clk);
      edge_raw = e;
      dir_raw  = d;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic detent_up();
      set_raw(1'b0, 1'b1);
      set_raw(1'b1, 1'b1);
      set_raw(1'b1, 1'b0);
      set_raw(1'b0, 1'b0);
      exp_pos = (exp_pos >= MAXP) ? 0 : exp_pos + 1;
   endtask

   task automatic detent_down();
      set_raw(1'b1, 1'b0);
      set_raw(1'b1, 1'b1);
      set_raw(1'b0, 1'b1);
      set_raw(1'b0, 1'b0);
      exp_pos = (exp_pos == 0) ? 0 : exp_pos - 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk_state("R1");
      rst = 1'b0;
      repeat (HOLD) @(negedge clk);
      chk_state("R1");

      // R5 R7: nine up detents
      for (int n = 0; n < 9; n++) begin
         detent_up();
         chk_state("R5");
      end

      // R8: latency from raw change to position and LED
      set_raw(1'b0, 1'b1);
      @(negedge clk);
      edge_raw = 1'b1;
      dir_raw  = 1'b1;
      repeat (3) @(posedge clk);
      #1 chk_pos("R8 before fourth edge", 9);
      @(posedge clk);
      #1 chk_pos("R8 at fourth edge", 10);
      chk_led("R8 led still old", 8'h00);
      @(posedge clk);
      #1 chk_led("R8 led one clock later", 8'h01);
      repeat (HOLD) @(negedge clk);
      set_raw(1'b1, 1'b0);
      set_raw(1'b0, 1'b0);
      exp_pos = 10;
      chk_state("R8");

      // R5 R6 R7: sweep past the top bound, wrap to zero
      for (int n = 0; n < 75; n++) begin
         detent_up();
         chk_state(exp_pos == 0 ? "R6 wrap" : "R5");
      end
      chk_pos("R6 after wrap", 4);

      // R2: chatter between (0,1) and (0,0) makes no step
      for (int n = 0; n < 5; n++) begin
         set_raw(1'b0, 1'b1);
         set_raw(1'b0, 1'b0);
      end
      chk_state("R2 chatter low");

      // R3: direction held from last mixed state, jump (0,0)->(1,1)
      set_raw(1'b1, 1'b1);
      exp_pos = exp_pos + 1;
      chk_state("R3 held up");

      // R4: chatter between (1,1) and (1,0), and long hold, make no step
      for (int n = 0; n < 5; n++) begin
         set_raw(1'b1, 1'b0);
         set_raw(1'b1, 1'b1);
      end
      repeat (40) @(negedge clk);
      chk_state("R4 no extra step");
      set_raw(1'b1, 1'b0);
      set_raw(1'b0, 1'b0);
      chk_state("R4");

      // R3: direction phase cleared by (1,0) and held through (0,0)
      set_raw(1'b1, 1'b0);
      set_raw(1'b0, 1'b0);
      set_raw(1'b1, 1'b1);
      exp_pos = exp_pos - 1;
      chk_state("R3 held down");
      set_raw(1'b0, 1'b1);
      set_raw(1'b0, 1'b0);

      // R5 R6: down to zero and beyond
      for (int n = 0; n < 8; n++) begin
         detent_down();
         chk_state(exp_pos == 0 ? "R6 floor" : "R5 down");
      end
      chk_pos("R6 floor", 0);

      // R1: reset from a non-zero position
      for (int n = 0; n < 10; n++) detent_up();
      chk_state("R7 mark");
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      exp_pos = 0;
      chk_state("R1 mid-run");
      rst = 1'b0;
      repeat (HOLD) @(negedge clk);
      detent_up();
      chk_state("R1 after release");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule